// File: doc/BRIEF.md
# Sleep-State Power Sequencer

This block follows the platform's sleep state (full power, suspend-to-RAM, soft-off) as selected by two active-low sleep-control inputs, and turns that state into rail enables, a CPU core enable, a delayed power-good output, a delayed resume-reset release and a supply-off request for the external power supply. A free-running one-cycle millisecond tick drives every timer, so all delays are counted in ticks rather than clock cycles.

It also guards the four main rails. Each rail has an under-voltage flag and an over-current flag. An external fault input can drop every rail while the platform is at full power. Faults are held in latches. Software chooses whether the latches clear when the soft-off request is asserted and released again, or only when the whole block is reset. Software can also choose to let any rail fault trip the whole group, to let a rail fault switch the supply off, and to force the supply off directly.

Rail index order is fixed: bit 0 is the memory rail, bit 1 the termination rail, bit 2 the analog rail and bit 3 the link rail.

Top module: `acpi_seq`

## Requirements
- R1: The requested state is decoded with soft-off first: `slp5_n`=0 requests soft-off, otherwise `slp3_n`=0 requests suspend, otherwise full power. From full power, a suspend or soft-off request is taken at the next clock edge. From suspend, a full-power request returns to full power at the next edge. Reset starts in soft-off.
- R2: In suspend, a soft-off request is ignored, and the block stays in suspend until full power is requested.
- R3: From soft-off, a full-power request passes through suspend for exactly one cycle and then enters full power, whatever the request is in that cycle. A suspend request made while in soft-off leaves the block in soft-off.
- R4: Rail demand is 4'b1111 in full power while `atx_good`=1, 4'b0001 (memory only) in suspend, and 4'b0000 in soft-off. `rail_en` is the demand with the fault-killed rails removed. `core_en`=1 only in full power with `atx_good`=1 and all four rails enabled.
- R5: `rsm_rst_n` goes high once `sb_good` has been high for RSM_MS (66) ticks. It goes low in the same cycle that `sb_good` falls.
- R6: `pwr_ok` goes high once `core_en` and `core_good` have both been high for (`pg_dly_sel`+1)×100 ticks (00=100, 01=200, 10=300, 11=400). It drops in the same cycle that either of them falls.
- R7: If `prot_en[i]`=1, rail i is demanded, and `uv_flag[i]` or `oc_flag[i]` is 1 at a clock edge, the rail i latch is set and rail i is off from the next cycle. When `prot_en[i]`=0, the flags for rail i have no effect.
- R8: With `shared_shdn`=1, any set rail latch turns off all four rails.
- R9: With `fault_en`=1, `fault_n`=0 in full power sets an external-fault latch that turns off all four rails from the next cycle. With `fault_en`=0, or outside full power, `fault_n` is ignored.
- R10: With `recover_by_s5`=1, all fault latches clear at every edge where `slp5_n`=0, unless a latch is being set at that same edge (setting wins). With `recover_by_s5`=0, the latches clear only on reset.
- R11: With `fault_to_supply`=1, any set rail latch forces `supply_off`=1 at once.
- R12: With `soft_off_en`=1 and `soft_off_set`=1, `supply_off`=1 at once.
- R13: If nothing forces it off, `supply_off` is 0 exactly when the state is full power or `pson_in_n`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| slp3_n | input | 1 | Suspend request, active low |
| slp5_n | input | 1 | Soft-off request, active low |
| pson_in_n | input | 1 | Manual supply-on request, active low |
| sb_good | input | 1 | Standby supply valid |
| atx_good | input | 1 | Main supply power good |
| core_good | input | 1 | CPU core supply ready |
| fault_n | input | 1 | External fault, active low |
| uv_flag | input | 4 | Per-rail under-voltage flags |
| oc_flag | input | 4 | Per-rail over-current flags |
| prot_en | input | 4 | Per-rail protection enables |
| fault_en | input | 1 | Enable for the external fault input |
| recover_by_s5 | input | 1 | 1: latches clear on a soft-off toggle; 0: reset only |
| fault_to_supply | input | 1 | Rail faults force the supply off |
| soft_off_en | input | 1 | Enables software supply-off forcing |
| soft_off_set | input | 1 | Software supply-off command |
| shared_shdn | input | 1 | A fault on one rail shuts down all rails |
| pg_dly_sel | input | 2 | Power-good delay select |
| rail_en | output | 4 | Rail enables |
| core_en | output | 1 | CPU core supply enable |
| pwr_ok | output | 1 | Delayed power-good |
| rsm_rst_n | output | 1 | Resume reset, active low |
| supply_off | output | 1 | 1 requests the main supply off |

## Verification
A fault latch can be set and the soft-off recovery clear can be applied at the same clock edge. This happens when the external fault is active in full power and soft-off is requested in that same cycle. The bench creates this collision on purpose and then releases soft-off on the very next cycle, so no later edge can clear the latch. The block then returns to full power with every rail still off, which shows that setting the latch won over clearing it. The bench also steps through the one-cycle suspend transit that comes from soft-off, and checks that the rejected suspend-to-off request shows up at the rail and supply outputs.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;

  typedef enum logic [1:0] {
    PS_S0 = 2'd0,
    PS_S3 = 2'd1,
    PS_S5 = 2'd2
  } pstate_t;

  // Soft-off has priority over suspend.
  function automatic pstate_t req_decode(input logic s3n, input logic s5n);
    if (!s5n)      return PS_S5;
    else if (!s3n) return PS_S3;
    else           return PS_S0;
  endfunction

  // Power-good delay in ticks: (sel + 1) steps.
  function automatic int unsigned pg_delay_ms(input logic [1:0] sel,
                                              input int unsigned step);
    return (int'(sel) + 1) * step;
  endfunction

endpackage

// File: rtl/acpi_seq_fsm.sv
module acpi_seq_fsm
  import acpi_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_t req,
  output pstate_t st_q
);
  logic    via5_q;
  pstate_t st_d;
  logic    via5_d;

  always_comb begin
    st_d   = st_q;
    via5_d = 1'b0;
    unique case (st_q)
      PS_S0: if (req != PS_S0) st_d = req;
      PS_S3: if (via5_q || req == PS_S0) st_d = PS_S0;
      PS_S5: if (req == PS_S0) begin
               st_d   = PS_S3;
               via5_d = 1'b1;
             end
      default: st_d = PS_S5;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_S5;
      via5_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      via5_q <= via5_d;
    end
  end
endmodule

// File: rtl/acpi_seq_delay.sv
module acpi_seq_delay #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic          reached;

  assign reached = (cnt_q >= limit);
  assign done    = en && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!en)                 cnt_q <= '0;
    else if (tick && !reached)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/acpi_seq_prot.sv
module acpi_seq_prot #(
  parameter int N_RAIL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_RAIL-1:0] rail_dem,
  input  logic [N_RAIL-1:0] uv_flag,
  input  logic [N_RAIL-1:0] oc_flag,
  input  logic [N_RAIL-1:0] prot_en,
  input  logic              in_s0,
  input  logic              fault_en,
  input  logic              fault_n,
  input  logic              recover_by_s5,
  input  logic              slp5_n,
  input  logic              shared_shdn,
  output logic [N_RAIL-1:0] kill,
  output logic              any_rail_flt
);
  logic [N_RAIL-1:0] flt_q;
  logic [N_RAIL-1:0] flt_set;
  logic              ext_q;
  logic              ext_set;
  logic              flt_clr;

  assign flt_clr = recover_by_s5 && !slp5_n;
  assign ext_set = fault_en && !fault_n && in_s0;

  for (genvar i = 0; i < N_RAIL; i++) begin : g_latch
    assign flt_set[i] = prot_en[i] && rail_dem[i] && (uv_flag[i] || oc_flag[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flt_q[i] <= 1'b0;
      else if (flt_set[i]) flt_q[i] <= 1'b1;
      else if (flt_clr)    flt_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ext_q <= 1'b0;
    else if (ext_set) ext_q <= 1'b1;
    else if (flt_clr) ext_q <= 1'b0;
  end

  assign any_rail_flt = |flt_q;
  assign kill = (shared_shdn && any_rail_flt) || ext_q ? {N_RAIL{1'b1}} : flt_q;
endmodule

// File: rtl/acpi_seq.sv
module acpi_seq
  import acpi_seq_pkg::*;
#(
  parameter int N_RAIL     = 4,
  parameter int MEM_RAIL   = 0,
  parameter int RSM_MS     = 66,
  parameter int PG_STEP_MS = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              slp3_n,
  input  logic              slp5_n,
  input  logic              pson_in_n,
  input  logic              sb_good,
  input  logic              atx_good,
  input  logic              core_good,
  input  logic              fault_n,
  input  logic [N_RAIL-1:0] uv_flag,
  input  logic [N_RAIL-1:0] oc_flag,
  input  logic [N_RAIL-1:0] prot_en,
  input  logic              fault_en,
  input  logic              recover_by_s5,
  input  logic              fault_to_supply,
  input  logic              soft_off_en,
  input  logic              soft_off_set,
  input  logic              shared_shdn,
  input  logic [1:0]        pg_dly_sel,
  output logic [N_RAIL-1:0] rail_en,
  output logic              core_en,
  output logic              pwr_ok,
  output logic              rsm_rst_n,
  output logic              supply_off
);
  localparam int PG_MAX  = 4 * PG_STEP_MS;
  localparam int CNT_MAX = (PG_MAX > RSM_MS) ? PG_MAX : RSM_MS;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [N_RAIL-1:0] MEM_MASK = N_RAIL'(1) << MEM_RAIL;

  pstate_t           st_q;
  pstate_t           req;
  logic [N_RAIL-1:0] rail_dem;
  logic [N_RAIL-1:0] kill;
  logic              any_rail_flt;
  logic              force_off;
  logic              pg_cond;
  logic [CW-1:0]     pg_limit;

  assign req = req_decode(slp3_n, slp5_n);

  acpi_seq_fsm u_fsm (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .st_q (st_q)
  );

  always_comb begin
    unique case (st_q)
      PS_S0:   rail_dem = atx_good ? {N_RAIL{1'b1}} : '0;
      PS_S3:   rail_dem = MEM_MASK;
      default: rail_dem = '0;
    endcase
  end

  acpi_seq_prot #(.N_RAIL(N_RAIL)) u_prot (
    .clk          (clk),
    .rst_n        (rst_n),
    .rail_dem     (rail_dem),
    .uv_flag      (uv_flag),
    .oc_flag      (oc_flag),
    .prot_en      (prot_en),
    .in_s0        (st_q == PS_S0),
    .fault_en     (fault_en),
    .fault_n      (fault_n),
    .recover_by_s5(recover_by_s5),
    .slp5_n       (slp5_n),
    .shared_shdn  (shared_shdn),
    .kill         (kill),
    .any_rail_flt (any_rail_flt)
  );

  assign rail_en = rail_dem & ~kill;
  assign core_en = (st_q == PS_S0) && atx_good && (&rail_en);

  acpi_seq_delay #(.CW(CW)) u_rsm (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (sb_good),
    .tick (ms_tick),
    .limit(CW'(RSM_MS)),
    .done (rsm_rst_n)
  );

  assign pg_cond  = core_en && core_good;
  assign pg_limit = CW'(pg_delay_ms(pg_dly_sel, PG_STEP_MS));

  acpi_seq_delay #(.CW(CW)) u_pg (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (pg_cond),
    .tick (ms_tick),
    .limit(pg_limit),
    .done (pwr_ok)
  );

  assign force_off  = (fault_to_supply && any_rail_flt) || (soft_off_en && soft_off_set);
  assign supply_off = !((st_q == PS_S0) || !pson_in_n) || force_off;
endmodule

// File: rtl/acpi_seq_chk.sv
module acpi_seq_chk
  import acpi_seq_pkg::*;
#(
  parameter int N_RAIL   = 4,
  parameter int MEM_RAIL = 0
) (
  input logic              clk,
  input logic              rst_n,
  input pstate_t           st_q,
  input logic [N_RAIL-1:0] rail_en,
  input logic              core_en,
  input logic              core_good,
  input logic              pwr_ok,
  input logic              sb_good,
  input logic              rsm_rst_n,
  input logic              fault_en,
  input logic              fault_n,
  input logic              soft_off_en,
  input logic              soft_off_set,
  input logic              supply_off
);
  localparam logic [N_RAIL-1:0] MEM_MASK = N_RAIL'(1) << MEM_RAIL;

  AST_NO_S3_TO_S5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == PS_S3 |=> st_q != PS_S5); // R2
  AST_S5_VIA_S3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == PS_S5 |=> st_q != PS_S0); // R3
  AST_S3_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == PS_S3 |-> (rail_en & ~MEM_MASK) == '0); // R4
  AST_CORE_IN_S0: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> st_q == PS_S0); // R4
  AST_RSM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sb_good) |-> !rsm_rst_n); // R5
  AST_PWOK_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok |-> core_en && core_good); // R6
  AST_EXT_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_en && !fault_n && st_q == PS_S0 |=> rail_en == '0); // R9
  AST_SOFT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off_en && soft_off_set |-> supply_off); // R12
endmodule

bind acpi_seq acpi_seq_chk #(.N_RAIL(N_RAIL), .MEM_RAIL(MEM_RAIL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_q        (st_q),
  .rail_en     (rail_en),
  .core_en     (core_en),
  .core_good   (core_good),
  .pwr_ok      (pwr_ok),
  .sb_good     (sb_good),
  .rsm_rst_n   (rsm_rst_n),
  .fault_en    (fault_en),
  .fault_n     (fault_n),
  .soft_off_en (soft_off_en),
  .soft_off_set(soft_off_set),
  .supply_off  (supply_off)
);

// File: tb/test_acpi_seq.sv
`timescale 1ns/1ps
module test_acpi_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, slp3_n = 1'b1, slp5_n = 1'b0, pson_in_n = 1'b1;
  logic sb_good = 1'b0, atx_good = 1'b0, core_good = 1'b0, fault_n = 1'b1;
  logic [3:0] uv_flag = '0, oc_flag = '0, prot_en = 4'b1111;
  logic fault_en = 1'b0, recover_by_s5 = 1'b1, fault_to_supply = 1'b0;
  logic soft_off_en = 1'b0, soft_off_set = 1'b0, shared_shdn = 1'b0;
  logic [1:0] pg_dly_sel = 2'b00;
  logic [3:0] rail_en;
  logic core_en, pwr_ok, rsm_rst_n, supply_off;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acpi_seq i_acpi_seq (.*);

  // Bench-side state model: 0 full power, 3 suspend, 5 soft-off
  int exp_st;
  bit exp_via;

  function automatic int req_of(input logic s3n, input logic s5n);
    return !s5n ? 5 : (!s3n ? 3 : 0);
  endfunction

  function automatic logic [3:0] rails_of(input int s);
    return s == 0 ? 4'b1111 : (s == 3 ? 4'b0001 : 4'b0000);
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic s5_toggle();
    @(negedge clk) slp5_n = 1'b0;
    @(negedge clk) slp5_n = 1'b1;
    step(2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    step(3);
    rst_n = 1'b1;
    step(1);
    // Reset state: soft-off
    chk(rail_en, 4'b0000, "R1 reset rails");
    chk(core_en, 0, "R4 reset core_en");
    chk(pwr_ok, 0, "R6 reset pwr_ok");
    chk(rsm_rst_n, 0, "R5 reset rsm");
    chk(supply_off, 1, "R13 reset supply_off");

    // R5 resume reset timing
    @(negedge clk) sb_good = 1'b1;
    tick(65);
    chk(rsm_rst_n, 0, "R5 before 66 ticks");
    tick(1);
    chk(rsm_rst_n, 1, "R5 at 66 ticks");
    @(negedge clk) sb_good = 1'b0;
    #1 chk(rsm_rst_n, 0, "R5 drop on loss");
    sb_good = 1'b1;

    // R3 soft-off to full power via one-cycle suspend
    atx_good = 1'b1;
    @(negedge clk) begin slp5_n = 1'b1; slp3_n = 1'b1; end
    step(1);
    chk(rail_en, 4'b0001, "R3 transit rails");
    chk(supply_off, 1, "R3 transit supply");
    step(1);
    chk(rail_en, 4'b1111, "R4 full-power rails");
    chk(supply_off, 0, "R13 full-power supply");
    chk(core_en, 1, "R4 core_en");

    // R6 power-good delay, select 01 = 200 ticks
    @(negedge clk) begin pg_dly_sel = 2'b01; core_good = 1'b1; end
    tick(199);
    chk(pwr_ok, 0, "R6 before 200 ticks");
    tick(1);
    chk(pwr_ok, 1, "R6 at 200 ticks");

    // R1 full power to suspend, R2 soft-off rejected in suspend
    @(negedge clk) slp3_n = 1'b0;
    step(1);
    chk(rail_en, 4'b0001, "R1 suspend rails");
    chk(core_en, 0, "R4 suspend core_en");
    chk(pwr_ok, 0, "R6 drop with core_en");
    @(negedge clk) slp5_n = 1'b0;
    step(3);
    chk(rail_en, 4'b0001, "R2 soft-off ignored in suspend");
    core_good = 1'b0;
    @(negedge clk) begin slp5_n = 1'b1; slp3_n = 1'b1; end
    step(1);
    chk(rail_en, 4'b1111, "R1 suspend to full power direct");

    // R1 full power to soft-off, R3 suspend request ignored in soft-off
    @(negedge clk) slp5_n = 1'b0;
    step(1);
    chk(rail_en, 4'b0000, "R1 soft-off rails");
    @(negedge clk) begin slp5_n = 1'b1; slp3_n = 1'b0; end
    step(3);
    chk(rail_en, 4'b0000, "R3 suspend ignored in soft-off");
    @(negedge clk) slp3_n = 1'b1;
    step(1);
    chk(rail_en, 4'b0001, "R3 transit again");
    step(1);
    chk(rail_en, 4'b1111, "R3 back in full power");

    // R7 per-rail latch, and disabled protection ignored
    @(negedge clk) uv_flag = 4'b0100;
    @(negedge clk) uv_flag = 4'b0000;
    chk(rail_en, 4'b1011, "R7 analog rail tripped");
    chk(core_en, 0, "R4 core_en off with rail down");
    @(negedge clk) begin prot_en = 4'b1101; oc_flag = 4'b0010; end
    @(negedge clk) oc_flag = 4'b0000;
    chk(rail_en, 4'b1011, "R7 disabled protection ignored");

    // R11 rail fault forces supply off
    @(negedge clk) fault_to_supply = 1'b1;
    #1 chk(supply_off, 1, "R11 fault forces supply off");
    fault_to_supply = 1'b0;
    #1 chk(supply_off, 0, "R11 released");

    // R10 recovery modes
    recover_by_s5 = 1'b0;
    s5_toggle();
    chk(rail_en, 4'b1011, "R10 latch held without toggle recovery");
    recover_by_s5 = 1'b1;
    s5_toggle();
    chk(rail_en, 4'b1111, "R10 toggle clears latch");
    prot_en = 4'b1111;

    // R8 shared shutdown
    @(negedge clk) begin shared_shdn = 1'b1; oc_flag = 4'b1000; end
    @(negedge clk) oc_flag = 4'b0000;
    chk(rail_en, 4'b0000, "R8 shared shutdown");
    s5_toggle();
    chk(rail_en, 4'b1111, "R8 recovered");

    // R9 external fault
    @(negedge clk) fault_n = 1'b0;
    step(2);
    chk(rail_en, 4'b1111, "R9 fault ignored when disabled");
    @(negedge clk) fault_en = 1'b1;
    step(1);
    chk(rail_en, 4'b0000, "R9 fault shuts rails");
    @(negedge clk) fault_n = 1'b1;
    step(1);
    chk(rail_en, 4'b0000, "R9 latched after release");
    s5_toggle();
    chk(rail_en, 4'b1111, "R10 external latch cleared");
    @(negedge clk) slp3_n = 1'b0;
    @(negedge clk) fault_n = 1'b0;
    step(2);
    chk(rail_en, 4'b0001, "R9 fault ignored in suspend");
    @(negedge clk) begin fault_n = 1'b1; slp3_n = 1'b1; end
    step(1);
    chk(rail_en, 4'b1111, "R9 suspend exit clean");

    // R10 collision: set and clear at the same edge, set wins
    @(negedge clk) begin fault_n = 1'b0; slp5_n = 1'b0; end
    @(negedge clk) begin fault_n = 1'b1; slp5_n = 1'b1; end
    step(2);
    chk(rail_en, 4'b0000, "R10 set wins over clear");
    s5_toggle();
    chk(rail_en, 4'b1111, "R10 cleared after collision");
    fault_en = 1'b0;

    // R12 software force, R13 manual supply-on
    @(negedge clk) begin soft_off_en = 1'b1; soft_off_set = 1'b1; end
    #1 chk(supply_off, 1, "R12 soft force");
    soft_off_set = 1'b0;
    #1 chk(supply_off, 0, "R12 released");
    soft_off_en = 1'b0;
    @(negedge clk) slp5_n = 1'b0;
    step(1);
    chk(supply_off, 1, "R13 soft-off supply");
    pson_in_n = 1'b0;
    #1 chk(supply_off, 0, "R13 manual on in soft-off");
    pson_in_n = 1'b1;
    @(negedge clk) slp5_n = 1'b1;
    step(2);
    chk(rail_en, 4'b1111, "R1 back to full power");

    // Random state and supply-control traffic against the bench model
    exp_st = 0;
    exp_via = 0;
    for (int n = 0; n < 400; n++) begin
      int r;
      int rq;
      logic [3:0] xr;
      logic xo;
      r = int'($urandom % 8);
      slp5_n = (r != 0);
      slp3_n = !(r == 1 || r == 2);
      pson_in_n = ($urandom % 4) != 0;
      soft_off_en = $urandom % 2;
      soft_off_set = $urandom % 2;
      fault_to_supply = $urandom % 2;
      rq = req_of(slp3_n, slp5_n);
      if (exp_st == 0) begin
        exp_via = 0;
        if (rq != 0) exp_st = rq;
      end else if (exp_st == 3) begin
        if (exp_via || rq == 0) exp_st = 0;
        exp_via = 0;
      end else if (rq == 0) begin
        exp_st = 3;
        exp_via = 1;
      end
      @(negedge clk);
      xr = rails_of(exp_st);
      xo = !(exp_st == 0 || !pson_in_n) || (soft_off_en && soft_off_set);
      chk(rail_en, xr, "R1 R2 R3 random rails");
      chk(core_en, exp_st == 0, "R4 random core_en");
      chk(supply_off, xo, "R12 R13 random supply_off");
    end

    finish_run();
  end
endmodule